// File: doc/BRIEF.md
# Pointer upper-bound check unit

This block executes the pointer upper-bound check instruction in one cycle. It receives an instruction that has already been decoded: the second opcode byte, the prefix state, the operating mode, the index of the bound register, the address to check and the upper-bound field of the selected bound register. The address is either a register value or an effective address that the address generator has already computed in the same way as a load-effective-address operation. The block never reads memory.

Two opcode variants exist. In one, the stored upper bound is kept inverted and the unit complements it before comparing. In the other, the stored bound is compared as it is. Before any comparison, the unit screens out illegal encodings and raises an undefined-opcode fault for them. A legal check whose address lies above the bound raises a bound-range fault and writes a fixed status code. All outputs are registered and pulse one cycle after the qualifying `valid_i`.

Top module: `ub_check_unit`

## Requirements
- R1: With `opc_i` = 0x1A, the address is compared against the bitwise NOT of `ub_i`.
- R2: With `opc_i` = 0x1B, the address is compared against `ub_i` unchanged.
- R3: A range fault occurs only when the address is strictly greater than the effective bound. An address equal to the bound passes.
- R4: On a range fault, `br_fault_o` and `status_we_o` are 1 and `status_o` is 0x01. In every other cycle `status_o` is 0x00.
- R5: When `lock_i` is set, `ud_fault_o` is raised and no comparison result is reported.
- R6: A bound index `bnd_idx_i` of 4 or higher raises `ud_fault_o`. Bit 3 is the extension-prefix bit.
- R7: Outside 64-bit mode, addressing is 32-bit only when `cs_d_i` XOR `addr_ovr_i` is 1. Otherwise the access uses 16-bit addressing and raises `ud_fault_o`. In 64-bit mode these inputs never cause a fault.
- R8: In 64-bit mode the comparison is unsigned over 64 bits. Otherwise it is unsigned over bits [31:0] of both operands, and the upper bits are ignored.
- R9: `ud_fault_o` takes priority over the range fault. When it fires, `br_fault_o` and `status_we_o` stay 0.
- R10: The outputs are registered and pulse for one cycle, in the cycle after `valid_i`. They stay 0 when `valid_i` is low or when `opc_i` is any byte other than 0x1A or 0x1B.
- R11: `flag_we_o` and `mem_req_o` are never asserted.
- R12: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies all inputs for one check |
| opc_i | input | 8 | Second opcode byte after the escape |
| lock_i | input | 1 | LOCK prefix present |
| addr_ovr_i | input | 1 | Address-size override prefix present |
| cs_d_i | input | 1 | Code-segment default-size bit |
| mode64_i | input | 1 | 64-bit mode active |
| bnd_idx_i | input | 4 | Bound register index; bit 3 from the extension prefix |
| addr_i | input | 64 | Register value or computed effective address |
| ub_i | input | 64 | Stored upper-bound field of the selected register |
| br_fault_o | output | 1 | Bound-range fault pulse |
| ud_fault_o | output | 1 | Undefined-opcode fault pulse |
| status_we_o | output | 1 | Bound-status write strobe |
| status_o | output | 8 | Bound-status value |
| flag_we_o | output | 1 | Arithmetic flag write; tied low |
| mem_req_o | output | 1 | Memory request; tied low |

## Verification
The assertions check, on every cycle, that the two faults never fire together, that every output pulse follows a valid input, that a LOCK prefix or an out-of-range index always produces an undefined-opcode fault, and that the status value and its write strobe track the range fault. Only the bench's scenarios can show the comparison values themselves. These are the inverted and plain bounds, the equal-to-bound edge, the 32-bit truncation in which the upper bits are ignored, and the addressing-size combinations of the two prefix and segment bits. The bench checks them against a behavioural model.

// File: rtl/ub_check_pkg.sv
package ub_check_pkg;
  localparam logic [7:0] OPC_INV   = 8'h1A;
  localparam logic [7:0] OPC_PLAIN = 8'h1B;
  localparam logic [7:0] ST_RANGE  = 8'h01;

  typedef struct packed {
    logic ours;
    logic invert;
    logic ud;
  } screen_t;
endpackage

// File: rtl/ub_legal_screen.sv
module ub_legal_screen
  import ub_check_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int NUM_BND = 4
) (
  input  logic [7:0]       opc_i,
  input  logic             lock_i,
  input  logic             addr_ovr_i,
  input  logic             cs_d_i,
  input  logic             mode64_i,
  input  logic [IDX_W-1:0] bnd_idx_i,
  output screen_t          scr_o
);
  localparam logic [IDX_W-1:0] IDX_LIM = IDX_W'(NUM_BND);

  logic idx_bad, addr16;

  always_comb begin
    idx_bad = (bnd_idx_i >= IDX_LIM);
    // 32-bit addressing needs exactly one of D bit and override
    addr16  = !mode64_i && !(cs_d_i ^ addr_ovr_i);
    scr_o.ours   = (opc_i == OPC_INV) || (opc_i == OPC_PLAIN);
    scr_o.invert = (opc_i == OPC_INV);
    scr_o.ud     = scr_o.ours && (lock_i || idx_bad || addr16);
  end
endmodule

// File: rtl/ub_bound_cmp.sv
module ub_bound_cmp #(
  parameter int ADDR_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              mode64_i,
  input  logic              invert_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] ub_i,
  output logic              over_o
);
  localparam int HI_W = ADDR_W - NARROW_W;

  logic [ADDR_W-1:0] bnd_eff, a_m, b_m;

  assign bnd_eff = invert_i ? ~ub_i : ub_i;

  generate
    if (HI_W > 0) begin : g_mask
      assign a_m = mode64_i ? addr_i  : {{HI_W{1'b0}}, addr_i[NARROW_W-1:0]};
      assign b_m = mode64_i ? bnd_eff : {{HI_W{1'b0}}, bnd_eff[NARROW_W-1:0]};
    end else begin : g_flat
      assign a_m = addr_i;
      assign b_m = bnd_eff;
    end
  endgenerate

  assign over_o = (a_m > b_m);
endmodule

// File: rtl/ub_fault_reg.sv
module ub_fault_reg
  import ub_check_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  screen_t    scr_i,
  input  logic       over_i,
  output logic       br_fault_o,
  output logic       ud_fault_o,
  output logic       status_we_o,
  output logic [7:0] status_o
);
  logic br_d, ud_d;

  always_comb begin
    ud_d = valid_i && scr_i.ud;
    br_d = valid_i && scr_i.ours && !scr_i.ud && over_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      br_fault_o  <= 1'b0;
      ud_fault_o  <= 1'b0;
      status_we_o <= 1'b0;
      status_o    <= 8'h00;
    end else begin
      br_fault_o  <= br_d;
      ud_fault_o  <= ud_d;
      status_we_o <= br_d;
      status_o    <= br_d ? ST_RANGE : 8'h00;
    end
  end

  a_r9_fault_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(br_fault_o && ud_fault_o));
  a_r4_status_val: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_we_o |-> (status_o == ST_RANGE));
endmodule

// File: rtl/ub_check_unit.sv
module ub_check_unit
  import ub_check_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int NARROW_W = 32,
  parameter int IDX_W    = 4,
  parameter int NUM_BND  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        opc_i,
  input  logic              lock_i,
  input  logic              addr_ovr_i,
  input  logic              cs_d_i,
  input  logic              mode64_i,
  input  logic [IDX_W-1:0]  bnd_idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] ub_i,
  output logic              br_fault_o,
  output logic              ud_fault_o,
  output logic              status_we_o,
  output logic [7:0]        status_o,
  output logic              flag_we_o,
  output logic              mem_req_o
);
  screen_t scr;
  logic    over;

  ub_legal_screen #(.IDX_W(IDX_W), .NUM_BND(NUM_BND)) u_screen (
    .opc_i(opc_i), .lock_i(lock_i), .addr_ovr_i(addr_ovr_i), .cs_d_i(cs_d_i),
    .mode64_i(mode64_i), .bnd_idx_i(bnd_idx_i), .scr_o(scr)
  );

  ub_bound_cmp #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_cmp (
    .mode64_i(mode64_i), .invert_i(scr.invert), .addr_i(addr_i), .ub_i(ub_i),
    .over_o(over)
  );

  ub_fault_reg u_freg (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .scr_i(scr), .over_i(over),
    .br_fault_o(br_fault_o), .ud_fault_o(ud_fault_o),
    .status_we_o(status_we_o), .status_o(status_o)
  );

  // no memory access, no flag update
  assign flag_we_o = 1'b0;
  assign mem_req_o = 1'b0;

  a_r10_pulse_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_fault_o || ud_fault_o) |-> $past(valid_i));
  a_r5_lock_ud: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && lock_i && (opc_i == OPC_INV || opc_i == OPC_PLAIN)) |=> ud_fault_o);
  a_r6_idx_ud: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bnd_idx_i >= IDX_W'(NUM_BND) && (opc_i == OPC_INV || opc_i == OPC_PLAIN))
      |=> (ud_fault_o && !status_we_o));
  a_r10_other_opc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || !(opc_i == OPC_INV || opc_i == OPC_PLAIN))
      |=> (!br_fault_o && !ud_fault_o && !status_we_o));
endmodule

// File: tb/ub_check_unit_bench.sv
module ub_check_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  opc = 8'h00;
  logic        lock = 1'b0, ovr = 1'b0, csd = 1'b1, m64 = 1'b0;
  logic [3:0]  idx = 4'd0;
  logic [63:0] addr = '0, ub = '0;
  logic        br, ud, we, fwe, mreq;
  logic [7:0]  st;
  int          checks = 0, fails = 0;

  always #5 clk = ~clk;

  ub_check_unit u_ub_check_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .opc_i(opc), .lock_i(lock),
    .addr_ovr_i(ovr), .cs_d_i(csd), .mode64_i(m64), .bnd_idx_i(idx),
    .addr_i(addr), .ub_i(ub), .br_fault_o(br), .ud_fault_o(ud),
    .status_we_o(we), .status_o(st), .flag_we_o(fwe), .mem_req_o(mreq)
  );

  task automatic compare(input string tag, input logic e_br, input logic e_ud);
    logic [7:0] e_st;
    e_st = e_br ? 8'h01 : 8'h00;
    checks++;
    if (br !== e_br || ud !== e_ud || we !== e_br || st !== e_st || fwe !== 1'b0 || mreq !== 1'b0) begin
      fails++;
      $display("FAIL %s: br/ud/we/st/flag/mem = %b/%b/%b/%h/%b/%b expected %b/%b/%b/%h/0/0",
               tag, br, ud, we, st, fwe, mreq, e_br, e_ud, e_br, e_st);
    end
  endtask

  // behavioural reference of one issue
  task automatic step(input string tag, input logic v, input logic [7:0] o, input logic lk,
                      input logic ov, input logic d, input logic w64, input logic [3:0] ix,
                      input logic [63:0] a, input logic [63:0] u);
    logic e_br, e_ud, mine;
    longint unsigned av, bv;
    valid = v; opc = o; lock = lk; ovr = ov; csd = d; m64 = w64; idx = ix; addr = a; ub = u;
    mine = (o == 8'h1A) || (o == 8'h1B);
    e_ud = v && mine && (lk || ix > 4'd3 || (!w64 && (d == ov)));
    bv = (o == 8'h1A) ? ~u : u;
    av = a;
    if (!w64) begin
      av = av & 64'hFFFF_FFFF;
      bv = bv & 64'hFFFF_FFFF;
    end
    e_br = v && mine && !e_ud && (av > bv);
    @(negedge clk);
    compare(tag, e_br, e_ud);
    valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    compare("R12 reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R12 after reset idle", 1'b0, 1'b0);
    // R2 plain bound, 64-bit
    step("R2 plain above",  1, 8'h1B, 0, 0, 0, 1, 4'd0, 64'h1000, 64'h0FFF);
    step("R2 plain below",  1, 8'h1B, 0, 0, 0, 1, 4'd1, 64'h0FFE, 64'h0FFF);
    step("R3 plain equal",  1, 8'h1B, 0, 0, 0, 1, 4'd2, 64'h0FFF, 64'h0FFF);
    // R1 inverted bound
    step("R1 inv above",    1, 8'h1A, 0, 0, 0, 1, 4'd3, 64'h1000, ~64'h0FFF);
    step("R1 inv below",    1, 8'h1A, 0, 0, 0, 1, 4'd3, 64'h0800, ~64'h0FFF);
    step("R3 inv equal",    1, 8'h1A, 0, 0, 0, 1, 4'd0, 64'h0FFF, ~64'h0FFF);
    step("R1 inv raw would pass", 1, 8'h1A, 0, 0, 0, 1, 4'd0, 64'h10, 64'h20);
    step("R4 high unsigned", 1, 8'h1B, 0, 0, 0, 1, 4'd0, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF);
    // R8 32-bit truncation
    step("R8 upper addr bits ignored", 1, 8'h1B, 0, 0, 1, 0, 4'd0, 64'hFFFF_0000_0000_0010, 64'h20);
    step("R8 upper bound bits ignored", 1, 8'h1B, 0, 0, 1, 0, 4'd0, 64'h30, 64'hFFFF_0000_0000_0020);
    step("R8 inv 32-bit", 1, 8'h1A, 0, 0, 1, 0, 4'd1, 64'h0000_0001_0000_0100, ~64'h0000_0000_0000_0100);
    step("R8 inv 32-bit over", 1, 8'h1A, 0, 0, 1, 0, 4'd1, 64'h101, ~64'h100);
    // R7 addressing size
    step("R7 d=1 ovr=0 ok", 1, 8'h1B, 0, 0, 1, 0, 4'd0, 64'h5, 64'h4);
    step("R7 d=0 ovr=1 ok", 1, 8'h1B, 0, 1, 0, 0, 4'd0, 64'h5, 64'h4);
    step("R7 d=0 ovr=0 16bit", 1, 8'h1B, 0, 0, 0, 0, 4'd0, 64'h5, 64'h4);
    step("R7 d=1 ovr=1 16bit", 1, 8'h1A, 0, 1, 1, 0, 4'd0, 64'h5, 64'h4);
    step("R7 64-bit with override", 1, 8'h1B, 0, 1, 1, 1, 4'd0, 64'h5, 64'h4);
    // R5 lock, R9 priority
    step("R5 R9 lock with overflow", 1, 8'h1B, 1, 0, 0, 1, 4'd0, 64'hFF, 64'h1);
    step("R5 lock in range", 1, 8'h1A, 1, 0, 1, 0, 4'd0, 64'h0, 64'h0);
    // R6 index
    step("R6 idx 3 legal", 1, 8'h1B, 0, 0, 0, 1, 4'd3, 64'h9, 64'h8);
    step("R6 R9 idx 4", 1, 8'h1B, 0, 0, 1, 0, 4'd4, 64'h9, 64'h8);
    step("R6 idx 7", 1, 8'h1A, 0, 0, 0, 1, 4'd7, 64'h0, 64'h0);
    step("R6 idx 8 ext", 1, 8'h1B, 0, 0, 0, 1, 4'd8, 64'h0, 64'h0);
    step("R6 idx 15 ext", 1, 8'h1B, 0, 0, 0, 1, 4'd15, 64'hFF, 64'h0);
    // R10 qualification
    step("R10 valid low", 0, 8'h1B, 1, 0, 0, 1, 4'd9, 64'hFF, 64'h0);
    step("R10 other opcode", 1, 8'h1C, 1, 0, 0, 1, 4'd9, 64'hFF, 64'h0);
    step("R10 back-to-back 1", 1, 8'h1B, 0, 0, 0, 1, 4'd0, 64'hFF, 64'h0);
    step("R10 back-to-back 2", 1, 8'h1B, 0, 0, 0, 1, 4'd0, 64'hFF, 64'h0);
    @(negedge clk);
    compare("R10 pulse ends", 1'b0, 1'b0);
    step("R11 idle again", 0, 8'h00, 0, 0, 0, 0, 4'd0, 64'h0, 64'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule